// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the target side of a single-lane serial memory port. It answers identification, status-read, write-enable and status-write commands. The bus pins (chip select, serial clock, data in) are sampled by the local system clock through synchronizers. The serial clock edges are recovered from the sampled copies, so the whole responder sits in one clock domain. The controller sends an 8-bit opcode, then any dummy or address bytes. The responder then shifts reply bytes out most-significant bit first. The reply keeps repeating until chip select is released.

A write-enable latch is kept as bit 1 of an 8-bit status byte. A status write is honoured only when its frame comes directly after a write-enable frame. Any other frame in between, including an unknown or truncated one, breaks the pairing. The output is presented as a data bit plus an output-enable, so that the pad ring can build the three-state driver.

Top module: `flash_id_responder`

## Requirements
- R1: After reset, and whenever chip select is high, `miso_oe` is low. The bit and byte counters restart when chip select rises.
- R2: Bits on `mosi` are taken on rising `sck` edges, MSB first. `miso_oe` stays low during the opcode byte and during any dummy or address byte.
- R3: Opcode 9Fh replies 8Ch, 40h, 14h and repeats that triple for as long as chip select stays low.
- R4: Opcode 90h takes two dummy bytes and then an address byte. If the address LSB is 0 the reply is 8Ch, 13h; if it is 1 the reply is 13h, 8Ch. The pair repeats until chip select rises.
- R5: Opcode 05h streams the status byte over and over. Status bit 1 is the write-enable latch.
- R6: Opcode 06h sets the write-enable latch.
- R7: Opcode 01h with one data byte, sent in the frame right after an 06h frame, loads status bits 7:2 and 0 from the data and clears the write-enable latch. Data bit 1 is not stored.
- R8: A 01h frame that does not directly follow an 06h frame leaves the status byte unchanged. Any frame in between (known, unknown, or cut short before 8 bits) breaks the pairing.
- R9: An opcode outside {9Fh, 90h, 05h, 06h, 01h} leaves `miso_oe` low for the whole frame and changes no state.
- R10: `miso` changes only after a falling `sck` edge. Each reply byte goes out MSB first.
- R11: If chip select rises in the middle of a byte, the next frame still decodes its opcode from its own first eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the responder |
| miso | output | 1 | Serial data out of the responder |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
The status-write commit and the clearing of the write-enable latch land on the same clock edge and touch the same byte. On that edge the data byte tries to set bit 1 while the latch logic tries to clear it. The bench provokes this with a write-enable frame followed by a status write whose data has bit 1 set, often with all bits set. A later status read must show every other written bit with bit 1 at zero. Streams of random frames also mix paired and broken pairings, and each status read is compared with a bench model of the latch and register.

// File: rtl/fid_pkg.sv
package fid_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = 3;

   localparam logic [BYTE_W-1:0] OP_JEDEC = 8'h9F;
   localparam logic [BYTE_W-1:0] OP_DEVID = 8'h90;
   localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
   localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
   localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;

   localparam logic [IDX_W-1:0] DEVID_ADDR_IDX = 3'd3;
   localparam logic [IDX_W-1:0] WRSR_DATA_IDX  = 3'd1;

   typedef enum logic [2:0] {
      RPL_NONE,
      RPL_JEDEC,
      RPL_PAIR_A,
      RPL_PAIR_B,
      RPL_STATUS
   } reply_e;
endpackage

// File: rtl/fid_sync.sv
module fid_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fid_rx.sv
module fid_rx
   import fid_pkg::*;
#(
   parameter int DW = BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_q,
   input  logic             sck_rise,
   input  logic             mosi_q,
   output logic             byte_done,
   output logic [DW-1:0]    rx_byte,
   output logic [IDX_W-1:0] byte_idx
);
   localparam int BC_W = $clog2(DW);
   localparam logic [BC_W-1:0]  LAST_BIT = BC_W'(DW - 1);
   localparam logic [IDX_W-1:0] IDX_MAX  = '1;

   logic [DW-2:0]    sh;
   logic [BC_W-1:0]  bit_cnt;
   logic [IDX_W-1:0] byte_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         bit_cnt   <= '0;
         byte_cnt  <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
         byte_idx  <= '0;
      end else if (cs_q) begin
         bit_cnt   <= '0;
         byte_cnt  <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sck_rise) begin
            sh      <= {sh[DW-3:0], mosi_q};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt   <= '0;
               byte_done <= 1'b1;
               rx_byte   <= {sh, mosi_q};
               byte_idx  <= byte_cnt;
               if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fid_ctrl.sv
module fid_ctrl
   import fid_pkg::*;
#(
   parameter int DW = BYTE_W,
   parameter int WEL_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_q,
   input  logic             cs_rise,
   input  logic             byte_done,
   input  logic [DW-1:0]    rx_byte,
   input  logic [IDX_W-1:0] byte_idx,
   output reply_e           kind,
   output logic             wel,
   output logic [DW-1:0]    status
);
   logic [DW-1:0] op_q;
   logic [DW-1:0] st_bits;
   logic          pair_armed;
   logic          frame_wren;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q       <= '0;
         st_bits    <= '0;
         pair_armed <= 1'b0;
         frame_wren <= 1'b0;
         wel        <= 1'b0;
         kind       <= RPL_NONE;
      end else if (cs_q) begin
         if (cs_rise) pair_armed <= frame_wren;
         frame_wren <= 1'b0;
         op_q       <= '0;
         kind       <= RPL_NONE;
      end else if (byte_done) begin
         if (byte_idx == '0) begin
            op_q <= rx_byte;
            unique case (rx_byte)
               OP_JEDEC: kind <= RPL_JEDEC;
               OP_RDSR:  kind <= RPL_STATUS;
               OP_WREN: begin
                  wel        <= 1'b1;
                  frame_wren <= 1'b1;
               end
               default: kind <= RPL_NONE;
            endcase
         end else begin
            if (op_q == OP_DEVID && byte_idx == DEVID_ADDR_IDX)
               kind <= rx_byte[0] ? RPL_PAIR_B : RPL_PAIR_A;
            if (op_q == OP_WRSR && byte_idx == WRSR_DATA_IDX && pair_armed) begin
               st_bits <= rx_byte;
               wel     <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      status          = st_bits;
      status[WEL_BIT] = wel;
   end
endmodule

// File: rtl/fid_tx.sv
module fid_tx
   import fid_pkg::*;
#(
   parameter int DW = BYTE_W,
   parameter logic [DW-1:0] MFR_ID   = 8'h8C,
   parameter logic [DW-1:0] TYPE_ID  = 8'h40,
   parameter logic [DW-1:0] CAP_ID   = 8'h14,
   parameter logic [DW-1:0] DEV_ID   = 8'h13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_q,
   input  logic          sck_fall,
   input  reply_e        kind,
   input  logic [DW-1:0] status,
   output logic          miso,
   output logic          miso_oe
);
   localparam int BC_W = $clog2(DW);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DW - 1);

   logic [DW-2:0]   tx_sh;
   logic [BC_W-1:0] bit_cnt;
   logic [1:0]      seq;
   logic [DW-1:0]   cur_byte;
   logic [1:0]      seq_next;

   always_comb begin
      unique case (kind)
         RPL_JEDEC: begin
            unique case (seq)
               2'd0:    cur_byte = MFR_ID;
               2'd1:    cur_byte = TYPE_ID;
               default: cur_byte = CAP_ID;
            endcase
         end
         RPL_PAIR_A: cur_byte = seq[0] ? DEV_ID : MFR_ID;
         RPL_PAIR_B: cur_byte = seq[0] ? MFR_ID : DEV_ID;
         RPL_STATUS: cur_byte = status;
         default:    cur_byte = '0;
      endcase
      if (kind == RPL_JEDEC) seq_next = (seq == 2'd2) ? 2'd0 : seq + 2'd1;
      else                   seq_next = {1'b0, ~seq[0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         bit_cnt <= '0;
         seq     <= '0;
         miso    <= 1'b0;
         miso_oe <= 1'b0;
      end else if (cs_q) begin
         bit_cnt <= '0;
         seq     <= '0;
         miso_oe <= 1'b0;
      end else if (sck_fall && kind != RPL_NONE) begin
         miso_oe <= 1'b1;
         if (bit_cnt == '0) begin
            {miso, tx_sh} <= cur_byte;
         end else begin
            miso  <= tx_sh[DW-2];
            tx_sh <= {tx_sh[DW-3:0], 1'b0};
         end
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            seq     <= seq_next;
         end
      end
   end
endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
   import fid_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DW = BYTE_W,
   parameter int WEL_BIT = 1,
   parameter logic [DW-1:0] MFR_ID  = 8'h8C,
   parameter logic [DW-1:0] TYPE_ID = 8'h40,
   parameter logic [DW-1:0] CAP_ID  = 8'h14,
   parameter logic [DW-1:0] DEV_ID  = 8'h13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   output logic miso,
   output logic miso_oe
);
   localparam int PIN_W = 3;
   localparam logic [PIN_W-1:0] PIN_RST = 3'b100;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DW != BYTE_W) begin : g_bad_dw
         $error("DW must match the bus cycle width");
      end
      if (WEL_BIT < 0 || WEL_BIT >= DW) begin : g_bad_wel
         $error("WEL_BIT out of range");
      end
   endgenerate

   logic             cs_q, sck_q, mosi_q;
   logic             cs_d, sck_d;
   logic             sck_rise, sck_fall, cs_rise;
   logic             byte_done;
   logic [DW-1:0]    rx_byte;
   logic [IDX_W-1:0] byte_idx;
   reply_e           kind;
   logic             wel;
   logic [DW-1:0]    status;

   fid_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, mosi}),
      .q     ({cs_q, sck_q, mosi_q})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_q;
         sck_d <= sck_q;
      end
   end

   assign sck_rise = sck_q & ~sck_d & ~cs_q;
   assign sck_fall = ~sck_q & sck_d & ~cs_q;
   assign cs_rise  = cs_q & ~cs_d;

   fid_rx #(.DW(DW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_q      (cs_q),
      .sck_rise  (sck_rise),
      .mosi_q    (mosi_q),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .byte_idx  (byte_idx)
   );

   fid_ctrl #(.DW(DW), .WEL_BIT(WEL_BIT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_q      (cs_q),
      .cs_rise   (cs_rise),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .byte_idx  (byte_idx),
      .kind      (kind),
      .wel       (wel),
      .status    (status)
   );

   fid_tx #(
      .DW(DW), .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID), .CAP_ID(CAP_ID), .DEV_ID(DEV_ID)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_q     (cs_q),
      .sck_fall (sck_fall),
      .kind     (kind),
      .status   (status),
      .miso     (miso),
      .miso_oe  (miso_oe)
   );
endmodule

// File: rtl/flash_id_responder_chk.sv
module flash_id_responder_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_q,
   input logic sck_fall,
   input logic byte_done,
   input logic wel,
   input logic miso,
   input logic miso_oe
);
   // R1
   idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !miso_oe);

   // R1
   oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> !$past(cs_q));

   // R2
   oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> $past(sck_fall));

   // R10
   miso_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> $past(sck_fall));

   // R6
   wel_set_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(byte_done));

   // R7
   wel_clr_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel) |-> $past(byte_done));
endmodule

bind flash_id_responder flash_id_responder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_q      (cs_q),
   .sck_fall  (sck_fall),
   .byte_done (byte_done),
   .wel       (wel),
   .miso      (miso),
   .miso_oe   (miso_oe)
);

// File: tb/flash_id_responder_bench.sv
module flash_id_responder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 8;
   localparam int SEED       = 4242;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic miso;
   logic miso_oe;

   int n_chk = 0;
   int n_fail = 0;

   logic       wel_m = 1'b0;
   logic [7:0] st_m = 8'h00;
   logic       pair_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_id_responder u_flash_id_responder (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe)
   );

   function automatic logic [7:0] exp_jedec(int k);
      case (k % 3)
         0: return 8'h8C;
         1: return 8'h40;
         default: return 8'h14;
      endcase
   endfunction

   function automatic logic [7:0] exp_pair(logic [7:0] addr, int k);
      logic first_mfr;
      first_mfr = (addr[0] == 1'b0);
      if ((k % 2 == 0) == first_mfr) return 8'h8C;
      return 8'h13;
   endfunction

   function automatic logic [7:0] exp_status();
      logic [7:0] s;
      s = st_m;
      s[1] = wel_m;
      return s;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic frame_open();
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic frame_close();
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
      chk("R1 oe low after select released", int'(miso_oe), 0);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output int oe_cnt);
      oe_cnt = 0;
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF_SCK) @(negedge clk);
         rx[i] = miso;
         oe_cnt += int'(miso_oe);
         sck = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic send_hiz(input logic [7:0] b, input string req);
      logic [7:0] rx;
      int oe;
      xfer(b, rx, oe);
      chk(req, oe, 0);
   endtask

   task automatic do_jedec(input int nrep);
      logic [7:0] rx;
      int oe;
      frame_open();
      send_hiz(8'h9F, "R2 oe low in opcode byte");
      for (int k = 0; k < nrep; k++) begin
         xfer(8'h00, rx, oe);
         chk("R3 id byte", rx, exp_jedec(k));
         chk("R10 oe through reply byte", oe, 8);
      end
      frame_close();
      pair_m = 1'b0;
   endtask

   task automatic do_devid(input logic [7:0] addr, input int nrep);
      logic [7:0] rx;
      int oe;
      frame_open();
      send_hiz(8'h90, "R2 oe low in opcode byte");
      send_hiz(8'hA5, "R2 oe low in dummy byte");
      send_hiz(8'h3C, "R2 oe low in dummy byte");
      send_hiz(addr, "R2 oe low in address byte");
      for (int k = 0; k < nrep; k++) begin
         xfer(8'h00, rx, oe);
         chk("R4 device pair byte", rx, exp_pair(addr, k));
      end
      frame_close();
      pair_m = 1'b0;
   endtask

   task automatic do_rdsr(input int nrep);
      logic [7:0] rx;
      int oe;
      frame_open();
      send_hiz(8'h05, "R2 oe low in opcode byte");
      for (int k = 0; k < nrep; k++) begin
         xfer(8'h00, rx, oe);
         chk("R5 status stream", rx, exp_status());
      end
      frame_close();
      pair_m = 1'b0;
   endtask

   task automatic do_wren();
      frame_open();
      send_hiz(8'h06, "R6 oe low in write-enable frame");
      frame_close();
      wel_m = 1'b1;
      pair_m = 1'b1;
   endtask

   task automatic do_wrsr(input logic [7:0] d);
      frame_open();
      send_hiz(8'h01, "R7 oe low in status-write opcode");
      send_hiz(d, "R7 oe low in status-write data");
      frame_close();
      if (pair_m) begin
         st_m = d;
         wel_m = 1'b0;
      end
      pair_m = 1'b0;
   endtask

   task automatic do_unknown(input logic [7:0] op, input int nbytes);
      frame_open();
      send_hiz(op, "R9 oe low in unknown opcode");
      for (int k = 0; k < nbytes; k++) send_hiz(8'hFF, "R9 oe low after unknown opcode");
      frame_close();
      pair_m = 1'b0;
   endtask

   task automatic do_partial(input int nbits);
      frame_open();
      for (int i = 0; i < nbits; i++) begin
         mosi = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
         sck = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
         sck = 1'b0;
      end
      frame_close();
      pair_m = 1'b0;
   endtask

   function automatic logic [7:0] rand_unknown();
      logic [7:0] v;
      do v = 8'($urandom);
      while (v == 8'h9F || v == 8'h90 || v == 8'h05 || v == 8'h06 || v == 8'h01);
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(SEED);
      repeat (5) @(negedge clk);
      chk("R1 oe low in reset", int'(miso_oe), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 oe low after reset", int'(miso_oe), 0);

      do_rdsr(2);
      do_jedec(7);
      do_devid(8'h00, 5);
      do_devid(8'h01, 5);
      // R6: latch set and visible as status bit 1
      do_wren();
      do_rdsr(2);
      // R7: paired write with bit 1 set in the data
      do_wren();
      do_wrsr(8'hFF);
      do_rdsr(3);
      // R8: intervening status read breaks the pairing
      do_wren();
      do_rdsr(1);
      do_wrsr(8'h5A);
      do_rdsr(1);
      // R8, R9: unknown opcode breaks pairing
      do_wren();
      do_unknown(8'hC3, 2);
      do_wrsr(8'h00);
      do_rdsr(1);
      // R11: truncated frame, then a clean frame decodes
      do_wren();
      do_partial(4);
      do_wrsr(8'h00);
      do_jedec(3);
      do_rdsr(1);
      // R7: paired write clearing bits
      do_wren();
      do_wrsr(8'h00);
      do_rdsr(1);

      for (int it = 0; it < 45; it++) begin
         case ($urandom % 7)
            0: do_jedec(1 + int'($urandom % 5));
            1: do_devid(8'($urandom % 4), 1 + int'($urandom % 4));
            2: do_rdsr(1 + int'($urandom % 3));
            3: do_wren();
            4: do_wrsr(8'($urandom));
            5: do_unknown(rand_unknown(), int'($urandom % 3));
            default: begin
               do_wren();
               do_wrsr(8'($urandom));
               do_rdsr(1);
            end
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule